// File: doc/BRIEF.md
# Stack Pointer Offset Folding Unit

This unit sits in a stream of decoded micro-operations. Stack operations such as pushes, pops, calls and returns move the stack pointer implicitly. The unit does not issue a separate add or subtract for each of them. It keeps a running signed byte offset against the architectural stack pointer. Each memory stack operation leaves as a single operation, and its displacement field already holds the correct offset from the stack pointer.

The real register is brought up to date only when an operation names the stack pointer explicitly. At that point the unit first emits one synchronising operation that carries the accumulated offset, holds the triggering operation for that cycle, and clears the offset. If the offset is already zero, no synchronising operation is needed.

The path is combinational and in order, with a valid/ready handshake. A flush input discards the tracked offset.

Top module: `sp_offset_tracker`

## Requirements
- R1: After reset the tracked offset is 0, so the first POP leaves with displacement 0.
- R2: PUSH (kind code 1) and CALL (code 3) leave with displacement equal to the offset minus SLOT_BYTES (default 4), and that value becomes the new offset. Two pushes from offset 0 carry displacements -4 and -8.
- R3: POP (code 2) and RET (code 4) leave with displacement equal to the current offset, and the offset then rises by SLOT_BYTES.
- R4: Every PUSH, POP, CALL and RET uses exactly one output slot and keeps its own kind code and tag. No separate stack-pointer arithmetic is emitted for it.
- R5: An explicit stack-pointer use (code 5) with a nonzero offset first produces a SYNC operation (code 6) whose displacement is the offset. During that slot in_ready is 0. In the next slot the use passes with displacement 0, and the offset is 0 afterwards.
- R6: An explicit use arriving with offset 0 passes in its first slot with no SYNC.
- R7: flush clears the offset at the next clock edge. This takes priority over any update from an operation accepted in the same cycle.
- R8: While out_ready is 0, in_ready is 0 and the offset does not change.
- R9: Any other operation (code 0) passes with displacement 0 and leaves the offset unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| flush | input | 1 | Clears the tracked offset |
| in_valid | input | 1 | Input operation valid |
| in_kind | input | 3 | Input operation kind code |
| in_tag | input | TAG_W | Opaque operation identifier |
| in_ready | output | 1 | Input operation accepted this cycle |
| out_valid | output | 1 | Output operation valid |
| out_kind | output | 3 | Output kind (input kind, or 6 for SYNC) |
| out_disp | output | OFS_W | Signed displacement from the stack pointer |
| out_tag | output | TAG_W | Tag of the operation being presented |
| out_ready | input | 1 | Downstream accepts the output |

## Verification
The assertions check the following on every cycle: the size of each offset step after an accepted push or pop, that a SYNC always carries a nonzero delta and holds the input, that the offset is cleared after a SYNC or flush, and that the offset stays put when nothing is accepted. The displacement values across whole sequences of mixed operations can only be shown by the bench. So can the ordering of a SYNC ahead of the use that caused it, and the priority of flush over an operation accepted in the same cycle. The bench sweeps every four-operation sequence and keeps its own arithmetic model of the offset.

// File: rtl/sp_offset_tracker.sv
module sp_offset_tracker #(
  parameter int OFS_W      = 8,
  parameter int SLOT_BYTES = 4,
  parameter int TAG_W      = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    flush,
  input  logic                    in_valid,
  input  logic [2:0]              in_kind,
  input  logic [TAG_W-1:0]        in_tag,
  output logic                    in_ready,
  output logic                    out_valid,
  output logic [2:0]              out_kind,
  output logic signed [OFS_W-1:0] out_disp,
  output logic [TAG_W-1:0]        out_tag,
  input  logic                    out_ready
);
  localparam logic [2:0] K_OTHER = 3'd0;
  localparam logic [2:0] K_PUSH  = 3'd1;
  localparam logic [2:0] K_POP   = 3'd2;
  localparam logic [2:0] K_CALL  = 3'd3;
  localparam logic [2:0] K_RET   = 3'd4;
  localparam logic [2:0] K_SPUSE = 3'd5;
  localparam logic [2:0] K_SYNC  = 3'd6;
  localparam logic signed [OFS_W-1:0] STEP = OFS_W'(SLOT_BYTES);

  logic signed [OFS_W-1:0] off_q, off_d, off_dec, off_inc;
  logic goes_down, goes_up, need_sync, fire;

  assign off_dec   = off_q - STEP;
  assign off_inc   = off_q + STEP;
  assign goes_down = (in_kind == K_PUSH) || (in_kind == K_CALL);
  assign goes_up   = (in_kind == K_POP)  || (in_kind == K_RET);
  assign need_sync = in_valid && (in_kind == K_SPUSE) && (off_q != '0);

  assign out_valid = in_valid;
  assign out_tag   = in_tag;
  assign out_kind  = need_sync ? K_SYNC : in_kind;
  assign out_disp  = need_sync ? off_q : goes_down ? off_dec : goes_up ? off_q : '0;
  assign in_ready  = out_ready && !need_sync;
  assign fire      = out_valid && out_ready;

  always_comb begin
    off_d = off_q;
    if (fire) begin
      if (need_sync)      off_d = '0;
      else if (goes_down) off_d = off_dec;
      else if (goes_up)   off_d = off_inc;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     off_q <= '0;
    else if (flush) off_q <= '0;
    else            off_q <= off_d;
  end

  AST_PUSH_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !flush && (out_kind == K_PUSH || out_kind == K_CALL)) |=> off_q == $past(off_q) - STEP); // R2
  AST_POP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && !flush && (out_kind == K_POP || out_kind == K_RET)) |=> off_q == $past(off_q) + STEP); // R3
  AST_SYNC_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && out_kind == K_SYNC) |-> (out_disp != '0 && !in_ready)); // R5
  AST_SYNC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_kind == K_SYNC) |=> off_q == '0); // R5
  AST_USE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && out_kind == K_SPUSE) |-> off_q == '0); // R6
  AST_FLUSH_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> off_q == '0); // R7
  AST_STALL_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (!out_ready && !flush) |=> $stable(off_q)); // R8
  AST_STALL_NO_ACCEPT: assert property (@(posedge clk) disable iff (!rst_n)
    !out_ready |-> !in_ready); // R8
endmodule

// File: tb/sp_offset_tracker_tb.sv
module sp_offset_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int STEP = 4;

  logic clk = 0, rst_n = 0, flush = 0, in_valid = 0, out_ready = 1;
  logic [2:0] in_kind = 0;
  logic [7:0] in_tag = 0;
  logic in_ready, out_valid;
  logic [2:0] out_kind;
  logic signed [7:0] out_disp;
  logic [7:0] out_tag;
  int checks = 0, errors = 0;
  int m_off = 0;
  logic [7:0] tagc = 0;

  sp_offset_tracker dut_i (.clk(clk), .rst_n(rst_n), .flush(flush), .in_valid(in_valid),
    .in_kind(in_kind), .in_tag(in_tag), .in_ready(in_ready), .out_valid(out_valid),
    .out_kind(out_kind), .out_disp(out_disp), .out_tag(out_tag), .out_ready(out_ready));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  task automatic issue(input logic [2:0] k);
    int edisp;
    @(negedge clk);
    tagc++;
    in_valid = 1; in_kind = k; in_tag = tagc;
    #1;
    if (k == 3'd5 && m_off != 0) begin
      chk("R5 sync kind", out_kind, 6);
      chk("R5 sync delta", out_disp, m_off);
      chk("R5 hold", in_ready, 0);
      @(negedge clk); #1;
      m_off = 0;
    end
    if (k == 3'd1 || k == 3'd3)      edisp = m_off - STEP;
    else if (k == 3'd2 || k == 3'd4) edisp = m_off;
    else                             edisp = 0;
    chk("R4 kind", out_kind, k);
    chk("R4 tag", out_tag, tagc);
    chk("R6 accept", in_ready, 1);
    if (k == 3'd1 || k == 3'd3)      chk("R2 disp", out_disp, edisp);
    else if (k == 3'd2 || k == 3'd4) chk("R3 disp", out_disp, edisp);
    else                             chk("R9 disp", out_disp, 0);
    if (k == 3'd1 || k == 3'd3)      m_off = m_off - STEP;
    else if (k == 3'd2 || k == 3'd4) m_off = m_off + STEP;
    @(negedge clk);
    in_valid = 0;
  endtask

  task automatic do_flush();
    @(negedge clk);
    flush = 1;
    @(negedge clk);
    flush = 0;
    m_off = 0;
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    summary();
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk("R1 idle valid", out_valid, 0);
    issue(3'd2);
    chk("R1 offset after first pop", m_off, STEP);
    do_flush();

    for (int a = 0; a < 6; a++)
      for (int b = 0; b < 6; b++)
        for (int c = 0; c < 6; c++)
          for (int d = 0; d < 6; d++) begin
            issue(3'(a)); issue(3'(b)); issue(3'(c)); issue(3'(d));
            do_flush();
          end

    issue(3'd1); issue(3'd1);
    chk("R2 two pushes", m_off, -8);

    @(negedge clk);
    out_ready = 0; in_valid = 1; in_kind = 3'd1; in_tag = 8'hAA;
    for (int i = 0; i < 3; i++) begin
      #1;
      chk("R8 valid held", out_valid, 1);
      chk("R8 no accept", in_ready, 0);
      @(negedge clk);
    end
    in_valid = 0; out_ready = 1;
    issue(3'd2);

    @(negedge clk);
    in_valid = 1; in_kind = 3'd1; flush = 1;
    @(negedge clk);
    in_valid = 0; flush = 0; m_off = 0;
    issue(3'd2);
    chk("R7 flush wins", m_off, STEP);
    do_flush();

    issue(3'd3); issue(3'd3); issue(3'd5);
    chk("R5 offset cleared", m_off, 0);
    issue(3'd4);
    chk("R5 ret after sync", m_off, STEP);

    summary();
  end
endmodule